// File: doc/BRIEF.md
# Four-Lane Time-Ordered Event Queue

This block keeps pending simulation events sorted by timestamp and hands out the earliest one. It is built from four parallel shift-register units, each holding a sorted run of events. Every cycle it can take up to four new events, release one event to a consumer, and drop every stored event that refers to a given bead. All three operations complete in that one cycle.

An event carries a timestamp and two bead IDs. A pseudo-random permutation spreads the incoming events across the four units, so that each unit gets at most one new event per cycle. When an invalidation removes entries, it leaves gaps inside a unit. Surviving entries close these gaps by moving forward, by at most two cells per cycle. The output port offers the smallest timestamp among the four unit heads. The consumer takes it by holding a ready line high. The depth of each unit, the timestamp width, the ID width and the drop-counter width are parameters.

Top module: `evq_shift4`

## Requirements
- R1: After reset, `deq_valid` is 0, `full` is 4'b0000 and `ovf_cnt` is 0.
- R2: Each unit receives at most one new event per cycle.
  - Lane j goes to the unit given by a permutation of {0,1,2,3}.
  - The permutation is chosen by a 16-bit Fibonacci LFSR with taps at bits 15, 13, 12 and 10. The LFSR is seeded to 16'hACE1 and advances every cycle.
  - The LFSR value modulo 24 is decoded as a factorial-base (Lehmer) index.
  - As a result, DEPTH cycles of four-wide inserts fill every unit exactly, and the stored events come out in timestamp order.
- R3: `deq_valid` is high whenever any unit holds an entry in its head cell.
  - The outputs then show the head with the smallest timestamp.
  - That head is removed at the clock edge only when `deq_ready` is high. With `deq_ready` low, the offered event stays unchanged.
- R4: Equal timestamps are ordered as follows.
  - At the output, the head of the lowest-numbered unit wins.
  - Inside a unit, an event inserted in an earlier cycle stays ahead of one inserted later.
- R5: Inside every unit, occupied cells hold non-decreasing timestamps from cell 0 toward the tail.
- R6: When `inv_valid` is high, every stored entry whose first or second bead ID equals `inv_id` is removed at that edge. The number of entries removed is not limited.
- R7: Gaps are closed as follows.
  - Each surviving entry moves toward cell 0 by the number of gaps in front of it, capped at two cells per cycle.
  - After ceil(DEPTH/2) further cycles, the survivors come out in timestamp order.
  - No surviving entry is lost.
- R8: `full[u]` is high while the tail cell of unit u is occupied.
  - An event routed to a full unit is dropped.
  - `ovf_cnt` adds one for each dropped event, for example +4 when all units are full and four events arrive.
- R9: Insert, invalidation and dequeue in the same cycle all take effect.
  - The dequeue takes from the contents stored before the edge.
  - The invalidation affects only previously stored entries, so an event inserted in the same cycle survives even if it carries `inv_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 4 | Per-lane insert request |
| ins_ts | input | 4×TS_W | Per-lane event timestamp |
| ins_ida | input | 4×ID_W | Per-lane first bead ID |
| ins_idb | input | 4×ID_W | Per-lane second bead ID |
| inv_valid | input | 1 | Invalidation broadcast strobe |
| inv_id | input | ID_W | Bead ID whose events are removed |
| deq_ready | input | 1 | Consumer takes the offered event |
| deq_valid | output | 1 | An event is offered |
| deq_ts | output | TS_W | Timestamp of the offered event |
| deq_ida | output | ID_W | First bead ID of the offered event |
| deq_idb | output | ID_W | Second bead ID of the offered event |
| full | output | 4 | Per-unit tail-cell occupied flag |
| ovf_cnt | output | CNT_W | Count of dropped inserts |

## Verification
The bench sweeps all fifteen lane masks and fills all sixteen cells with four-wide bursts, then drains and compares each output against a sorted reference. A router that sent two lanes to one unit would trip the full flags early or lose events. Back-to-back broadcasts that strip three leading cells probe gap closing. A design that closed gaps too slowly, or moved the wrong cell, would offer an event out of order or drop one.

Equal-timestamp bursts in two cycles expose both tie rules: a wrong rule changes the alternation of bead IDs at the output. Writes into full units must move the drop counter by exactly the number of lost events. A combined insert, invalidate and dequeue cycle catches a design that lets the broadcast hit the new event, or that dequeues the freshly inserted one.

// File: rtl/evq_shift4.sv
module evq_shift4 #(
  parameter int DEPTH = 4,
  parameter int TS_W  = 8,
  parameter int ID_W  = 4,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            ins_valid,
  input  logic [3:0][TS_W-1:0]  ins_ts,
  input  logic [3:0][ID_W-1:0]  ins_ida,
  input  logic [3:0][ID_W-1:0]  ins_idb,
  input  logic                  inv_valid,
  input  logic [ID_W-1:0]       inv_id,
  input  logic                  deq_ready,
  output logic                  deq_valid,
  output logic [TS_W-1:0]       deq_ts,
  output logic [ID_W-1:0]       deq_ida,
  output logic [ID_W-1:0]       deq_idb,
  output logic [3:0]            full,
  output logic [CNT_W-1:0]      ovf_cnt
);
  localparam int NU = 4;
  localparam int PW = $clog2(DEPTH + 1);

  logic [TS_W-1:0] ts_q [NU][DEPTH];
  logic [TS_W-1:0] ts_d [NU][DEPTH];
  logic [ID_W-1:0] a_q  [NU][DEPTH];
  logic [ID_W-1:0] a_d  [NU][DEPTH];
  logic [ID_W-1:0] b_q  [NU][DEPTH];
  logic [ID_W-1:0] b_d  [NU][DEPTH];
  logic [NU-1:0][DEPTH-1:0] v_q, v_d;

  logic [15:0]     lfsr;
  logic [3:0][1:0] dest;
  logic [1:0]      win;
  logic            pop;
  logic [2:0]      drops;

  function automatic logic [3:0][1:0] perm_dec(input logic [4:0] n);
    logic [3:0][1:0] pool, res, dig;
    pool   = {2'd3, 2'd2, 2'd1, 2'd0};
    res    = '0;
    dig[0] = 2'(n / 5'd6);
    dig[1] = 2'((n % 5'd6) / 5'd2);
    dig[2] = 2'(n % 5'd2);
    dig[3] = 2'd0;
    for (int j = 0; j < 4; j++) begin
      res[j] = pool[dig[j]];
      for (int i = 0; i < 3; i++)
        if (i >= int'(dig[j])) pool[i] = pool[i+1];
    end
    return res;
  endfunction

  assign dest = perm_dec(5'(lfsr % 16'd24));
  assign pop  = deq_valid & deq_ready;

  always_comb
    for (int u = 0; u < NU; u++) full[u] = v_q[u][DEPTH-1];

  always_comb begin
    deq_valid = 1'b0;
    win       = '0;
    deq_ts    = '0;
    deq_ida   = '0;
    deq_idb   = '0;
    for (int u = 0; u < NU; u++)
      if (v_q[u][0] && (!deq_valid || ts_q[u][0] < deq_ts)) begin
        deq_valid = 1'b1;
        win       = 2'(u);
        deq_ts    = ts_q[u][0];
        deq_ida   = a_q[u][0];
        deq_idb   = b_q[u][0];
      end
  end

  logic [DEPTH-1:0] keep, cv, le;
  logic [TS_W-1:0]  c_ts [DEPTH];
  logic [ID_W-1:0]  c_a  [DEPTH];
  logic [ID_W-1:0]  c_b  [DEPTH];
  logic [1:0]       h;
  logic             rx, lat;
  logic [TS_W-1:0]  x_ts;
  logic [ID_W-1:0]  x_a, x_b;
  logic [PW-1:0]    p;

  always_comb begin
    drops = '0;
    for (int u = 0; u < NU; u++) begin
      for (int k = 0; k < DEPTH; k++)
        keep[k] = v_q[u][k]
                  && !(inv_valid && (a_q[u][k] == inv_id || b_q[u][k] == inv_id))
                  && !(pop && win == 2'(u) && k == 0);
      cv = '0;
      h  = '0;
      for (int k = 0; k < DEPTH; k++) begin
        c_ts[k] = '0;
        c_a[k]  = '0;
        c_b[k]  = '0;
      end
      for (int k = 0; k < DEPTH; k++)
        if (keep[k]) begin
          c_ts[k - int'(h)] = ts_q[u][k];
          c_a[k - int'(h)]  = a_q[u][k];
          c_b[k - int'(h)]  = b_q[u][k];
          cv[k - int'(h)]   = 1'b1;
        end else if (h != 2'd2) begin
          h = h + 2'd1;
        end
      rx = 1'b0; x_ts = '0; x_a = '0; x_b = '0;
      for (int j = 0; j < NU; j++)
        if (ins_valid[j] && dest[j] == 2'(u)) begin
          rx = 1'b1; x_ts = ins_ts[j]; x_a = ins_ida[j]; x_b = ins_idb[j];
        end
      if (rx && full[u]) drops = drops + 3'd1;
      lat = 1'b0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
        lat   = lat | (cv[k] && c_ts[k] <= x_ts);
        le[k] = lat;
      end
      p = PW'($countones(le));
      for (int k = 0; k < DEPTH; k++) begin
        ts_d[u][k] = c_ts[k];
        a_d[u][k]  = c_a[k];
        b_d[u][k]  = c_b[k];
        v_d[u][k]  = cv[k];
        if (rx && !full[u]) begin
          if (k == int'(p)) begin
            ts_d[u][k] = x_ts; a_d[u][k] = x_a; b_d[u][k] = x_b; v_d[u][k] = 1'b1;
          end else if (k > int'(p)) begin
            ts_d[u][k] = c_ts[(k == 0) ? 0 : k - 1];
            a_d[u][k]  = c_a[(k == 0) ? 0 : k - 1];
            b_d[u][k]  = c_b[(k == 0) ? 0 : k - 1];
            v_d[u][k]  = cv[(k == 0) ? 0 : k - 1];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v_q     <= '0;
      lfsr    <= 16'hACE1;
      ovf_cnt <= '0;
    end else begin
      v_q     <= v_d;
      lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ovf_cnt <= ovf_cnt + CNT_W'(drops);
    end

  always_ff @(posedge clk) begin
    ts_q <= ts_d;
    a_q  <= a_d;
    b_q  <= b_d;
  end

  logic [ID_W-1:0]          inv_id_q;
  logic [NU-1:0][DEPTH-1:0] stale;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) inv_id_q <= '0;
    else        inv_id_q <= inv_id;

  always_comb
    for (int u = 0; u < NU; u++)
      for (int k = 0; k < DEPTH; k++)
        stale[u][k] = v_q[u][k] && (a_q[u][k] == inv_id_q || b_q[u][k] == inv_id_q);

  for (genvar u = 0; u < NU; u++) begin : g_chk
    a_r3_head_min: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[u][0] |-> deq_valid && deq_ts <= ts_q[u][0]);
    for (genvar k = 0; k < DEPTH - 1; k++) begin : g_cell
      a_r5_sorted: assert property (@(posedge clk) disable iff (!rst_n)
        v_q[u][k] && v_q[u][k+1] |-> ts_q[u][k] <= ts_q[u][k+1]);
    end
  end

  a_r6_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && ins_valid == 4'd0 |=> stale == '0);

  a_r7_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_valid && ins_valid == 4'd0 && !pop |=> $countones(v_q) == $past($countones(v_q)));

  a_r3_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !inv_valid && ins_valid == 4'd0 |=> $countones(v_q) + 1 == $past($countones(v_q)));

  a_r8_drop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (&full) && (&ins_valid) |=> ovf_cnt == $past(ovf_cnt) + CNT_W'(4));
endmodule

// File: tb/evq_shift4_tb_top.sv
module evq_shift4_tb_top;
  localparam int CLK_P = 10;
  localparam int D     = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      ins_valid;
  logic [3:0][7:0] ins_ts;
  logic [3:0][3:0] ins_ida, ins_idb;
  logic            inv_valid;
  logic [3:0]      inv_id;
  logic            deq_ready;
  logic            deq_valid;
  logic [7:0]      deq_ts;
  logic [3:0]      deq_ida, deq_idb;
  logic [3:0]      full;
  logic [7:0]      ovf_cnt;

  always #(CLK_P / 2) clk = ~clk;

  evq_shift4 #(.DEPTH(D), .TS_W(8), .ID_W(4), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ts(ins_ts),
    .ins_ida(ins_ida), .ins_idb(ins_idb), .inv_valid(inv_valid), .inv_id(inv_id),
    .deq_ready(deq_ready), .deq_valid(deq_valid), .deq_ts(deq_ts),
    .deq_ida(deq_ida), .deq_idb(deq_idb), .full(full), .ovf_cnt(ovf_cnt)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] m_ts [64];
  logic [3:0] m_a  [64];
  logic [3:0] m_b  [64];
  logic       m_v  [64];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ins_valid = '0;
    inv_valid = 1'b0;
    deq_ready = 1'b0;
  endtask

  task automatic drive(input int lane, input int ts, input int a, input int b);
    ins_valid[lane] = 1'b1;
    ins_ts[lane]    = 8'(ts);
    ins_ida[lane]   = 4'(a);
    ins_idb[lane]   = 4'(b);
  endtask

  task automatic put(input int lane, input int ts, input int a, input int b);
    drive(lane, ts, a, b);
    for (int i = 0; i < 64; i++)
      if (!m_v[i]) begin
        m_v[i] = 1'b1; m_ts[i] = 8'(ts); m_a[i] = 4'(a); m_b[i] = 4'(b);
        break;
      end
  endtask

  task automatic m_inv(input int id);
    for (int i = 0; i < 64; i++)
      if (m_v[i] && (m_a[i] == 4'(id) || m_b[i] == 4'(id))) m_v[i] = 1'b0;
  endtask

  function automatic int m_min();
    int best = -1;
    for (int i = 0; i < 64; i++)
      if (m_v[i] && (best < 0 || m_ts[i] < m_ts[best])) best = i;
    return best;
  endfunction

  task automatic drain(input string tag);
    deq_ready = 1'b1;
    for (int n = 0; n < 64; n++) begin
      int i;
      i = m_min();
      if (i < 0) break;
      chk(deq_valid && deq_ts == m_ts[i], tag, int'(deq_ts), int'(m_ts[i]));
      m_v[i] = 1'b0;
      step();
    end
    deq_ready = 1'b0;
    chk(!deq_valid, {tag, " empty"}, int'(deq_valid), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
    ins_ts = '0; ins_ida = '0; ins_idb = '0; inv_id = '0;
    idle();
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(!deq_valid, "R1 deq_valid", int'(deq_valid), 0);
    chk(full == 4'd0, "R1 full", int'(full), 0);
    chk(ovf_cnt == 8'd0, "R1 ovf_cnt", int'(ovf_cnt), 0);

    // R2 every lane mask
    for (int m = 1; m < 16; m++) begin
      for (int l = 0; l < 4; l++)
        if (m[l]) put(l, (m * 16 + 13 - l * 3) & 255, l, l + 4);
      step();
      idle();
      chk(deq_valid, "R2 mask valid", int'(deq_valid), 1);
      drain("R2 mask order");
    end

    // R3 ready low holds the offered event
    put(0, 40, 1, 2);
    put(1, 30, 3, 4);
    step();
    idle();
    chk(deq_valid && deq_ts == 8'd30, "R3 min offered", int'(deq_ts), 30);
    step();
    step();
    chk(deq_valid && deq_ts == 8'd30 && deq_ida == 4'd3, "R3 hold", int'(deq_ts), 30);
    drain("R3 drain");

    // R4 ties: lowest unit first, arrival order within unit
    for (int l = 0; l < 4; l++) drive(l, 5, l + 1, 15);
    step();
    ins_valid = '0;
    for (int l = 0; l < 4; l++) drive(l, 5, l + 5, 15);
    step();
    idle();
    deq_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      bit early;
      early = (deq_ida >= 4'd1 && deq_ida <= 4'd4);
      chk(deq_valid && deq_ts == 8'd5 && early == ((k % 2) == 0), "R4 tie order",
          int'(deq_ida), (k % 2 == 0) ? 1 : 5);
      step();
    end
    deq_ready = 1'b0;
    chk(!deq_valid, "R4 empty", int'(deq_valid), 0);

    // R8 fill and overflow
    for (int c = 0; c < 4; c++) begin
      for (int l = 0; l < 4; l++) begin
        int k;
        k = c * 4 + l;
        put(l, (k * 37 + 11) & 255, k % 16, (k * 7 + 3) % 16);
      end
      step();
      if (c == 2) chk(full == 4'd0, "R2 not full after three", int'(full), 0);
    end
    idle();
    chk(full == 4'hF, "R2 R8 full after four bursts", int'(full), 15);
    chk(ovf_cnt == 8'd0, "R8 no drop yet", int'(ovf_cnt), 0);
    for (int l = 0; l < 4; l++) drive(l, 1, 0, 0);
    step();
    idle();
    chk(ovf_cnt == 8'd4, "R8 four dropped", int'(ovf_cnt), 4);
    chk(full == 4'hF, "R8 still full", int'(full), 15);
    drive(0, 2, 0, 0);
    drive(1, 2, 0, 0);
    step();
    idle();
    chk(ovf_cnt == 8'd6, "R8 two dropped", int'(ovf_cnt), 6);
    drain("R8 drain");

    // R6 R7 invalidation sweep
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 4; c++) begin
        for (int l = 0; l < 4; l++) begin
          int k;
          k = c * 4 + l;
          put(l, (k * 37 + s * 13 + 1) & 255, (k * 5 + s) % 16, (k * 3 + s + 7) % 16);
        end
        step();
      end
      idle();
      inv_valid = 1'b1;
      inv_id = 4'(s);
      m_inv(s);
      step();
      inv_id = 4'((s + 5) % 16);
      m_inv((s + 5) % 16);
      step();
      idle();
      step();
      step();
      drain("R6 R7 sweep");
    end

    // R9 insert, invalidate and dequeue in one cycle
    put(0, 10, 1, 2);
    put(1, 20, 3, 4);
    put(2, 30, 5, 6);
    step();
    idle();
    deq_ready = 1'b1;
    chk(deq_valid && deq_ts == 8'd10, "R9 offered", int'(deq_ts), 10);
    m_v[m_min()] = 1'b0;
    inv_valid = 1'b1;
    inv_id = 4'd3;
    m_inv(3);
    put(0, 5, 3, 9);
    step();
    idle();
    step();
    step();
    drain("R9 combined");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule